// File: doc/BRIEF.md
# Daisy-Chain Configuration Sequencer

This block sits on the host side of a chain of serial converter nodes. The nodes are wired in series, so each control word must carry a hop count that every node decrements before it passes the word on. The block walks a parameterised list of register writes. It expands each entry into one control word per node and sends the farthest node's copy first. Every node therefore receives its copy of a setting in the same frame, including the settings that change the serial clock. Each frame sync that arrives from the chain launches the next control word on the transmit line, so the words of one group go out on consecutive frames.

The last group is always the mode-change write to register 0. Until that word has gone out, the sample words shifting in from the chain are invalid and are dropped. After it, the transmit line carries a filler word that the nodes ignore. The received samples are presented on a stream output, each one tagged with the index of the node that produced it. The chain delivers the farthest node's sample first.

Top module: `daisy_cfg_seq`

## Requirements
- R1: Every control word has bit 15 = 1 (control), bit 14 = 0 (write), bits 13:11 = hop count, bits 10:8 = register address and bits 7:0 = register data. All words are shifted out MSB first.
- R2: Within one group, the words carry hop counts NUM_DEV-1, NUM_DEV-2 down to 0, in that order, on consecutive frames. For two nodes, the word with hop count 1 goes before the word with hop count 0.
- R3: Each cycle in which rx_fs_i is high launches one transmit word. In the following cycle tx_fs_o is high for one cycle and tx_sd_o carries bit 15. Bits 14 to 0 follow on the next 15 cycles.
- R4: Groups are sent in list order (entry 0 first). They are followed by a final group that writes register 0 with MODE_DATA.
- R5: Received words are discarded (sample_valid_o stays low) for every frame whose sync arrives before or with the sync that launches the last mode-change word.
- R6: Every word launched after the last mode-change word is the filler 0x7FFF.
- R7: A valid received word appears on sample_o with sample_valid_o high for one cycle, in the cycle after its 16th bit. Its dev_idx_o tag runs NUM_DEV, NUM_DEV-1, ..., 1 and then wraps back to NUM_DEV.
- R8: done_o rises in the cycle after the sync that launches the last mode-change word and stays high until reset.
- R9: If a group is partly sent and GAP_LIMIT cycles pass with no rx_fs_i, err_o sets and stays set, and the group restarts from its farthest-node word.
- R10: After reset, tx_fs_o, tx_sd_o, sample_valid_o, done_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_fs_i | input | 1 | Frame sync from the last node of the chain, high with bit 15 |
| rx_sd_i | input | 1 | Serial data from the chain, MSB first |
| tx_fs_o | output | 1 | Frame sync to the first node, high with bit 15 |
| tx_sd_o | output | 1 | Serial control word to the first node, MSB first |
| sample_o | output | 16 | Received sample word |
| sample_valid_o | output | 1 | sample_o holds a valid sample |
| dev_idx_o | output | IDX_W | Index of the node that produced sample_o |
| done_o | output | 1 | All groups, including the mode change, have been launched |
| err_o | output | 1 | Sticky: a gap interrupted a group |

## Verification
A wrong group or hop index appears at once in the next transmit word. It is also carried into every later word, so comparing each launched word against the expected sequence locates the fault to a single frame. A liveness flag that sets one frame early or late shows up within one frame. The fault is either a sample released from the frame that launches the mode change, or a valid sample missing on the frame after it. A tag counter that starts or wraps wrongly mislabels the first or the (NUM_DEV+1)th valid sample. A gap counter fault shows up as err_o missing or early, and as a repeated or skipped farthest-node word on the next frame.

// File: rtl/daisy_cfg_pkg.sv
package daisy_cfg_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] FILLER = 16'h7FFF;

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] val;
  } reg_wr_t;

  localparam int WR_W = $bits(reg_wr_t);

  function automatic logic [WORD_W-1:0] ctl_word(logic [2:0] hop, reg_wr_t wr);
    return {1'b1, 1'b0, hop, wr.addr, wr.val};
  endfunction
endpackage

// File: rtl/cfg_tx_shift.sv
module cfg_tx_shift
  import daisy_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              fs_o,
  output logic              sd_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  left_q;
  logic              first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (load_i) begin
      sh_q    <= word_i;
      left_q  <= CNT_W'(WORD_W);
      first_q <= 1'b1;
    end else begin
      first_q <= 1'b0;
      if (left_q != '0) begin
        sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign fs_o = first_q;
  assign sd_o = (left_q != '0) ? sh_q[WORD_W-1] : 1'b0;
endmodule

// File: rtl/cfg_rx_shift.sv
module cfg_rx_shift
  import daisy_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic              done_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fs_i) begin
        sh_q   <= {sh_q[WORD_W-2:0], sd_i};
        cnt_q  <= CNT_W'(1);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        sh_q <= {sh_q[WORD_W-2:0], sd_i};
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign word_o = sh_q;
endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import daisy_cfg_pkg::*;
#(
  parameter int                        NUM_DEV    = 2,
  parameter int                        NUM_GROUPS = 3,
  parameter logic [NUM_GROUPS*WR_W-1:0] GROUP_LIST = '0,
  parameter logic [7:0]                MODE_DATA  = 8'h11,
  parameter int                        GAP_LIMIT  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  output logic [WORD_W-1:0] word_o,
  output logic              live_o,
  output logic              err_o
);
  localparam int          GRP_W    = $clog2(NUM_GROUPS + 2);
  localparam int          GAP_W    = $clog2(GAP_LIMIT + 1);
  localparam logic [2:0]  HOP_TOP  = 3'(NUM_DEV - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NUM_GROUPS);
  localparam logic [GAP_W-1:0] GAP_END  = GAP_W'(GAP_LIMIT - 1);

  reg_wr_t tab [NUM_GROUPS+1];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_tab
    assign tab[g] = reg_wr_t'(GROUP_LIST[g*WR_W +: WR_W]);
  end
  assign tab[NUM_GROUPS] = '{addr: 3'd0, val: MODE_DATA};

  logic [GRP_W-1:0] grp_q;
  logic [2:0]       hop_q;
  logic [GAP_W-1:0] gap_q;
  logic             live_q, err_q;
  logic             mid;

  // a group is partly sent once its farthest word has gone out
  assign mid = !live_q && (hop_q != HOP_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      hop_q  <= HOP_TOP;
      gap_q  <= '0;
      live_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (fs_i) begin
      gap_q <= '0;
      if (!live_q) begin
        if (hop_q == 3'd0) begin
          hop_q <= HOP_TOP;
          if (grp_q == GRP_LAST) live_q <= 1'b1;
          else                   grp_q  <= grp_q + 1'b1;
        end else begin
          hop_q <= hop_q - 1'b1;
        end
      end
    end else if (mid) begin
      if (gap_q == GAP_END) begin
        err_q <= 1'b1;
        hop_q <= HOP_TOP;
        gap_q <= '0;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end else begin
      gap_q <= '0;
    end
  end

  assign word_o = live_q ? FILLER : ctl_word(hop_q, tab[grp_q]);
  assign live_o = live_q;
  assign err_o  = err_q;
endmodule

// File: rtl/cfg_smp_tag.sv
module cfg_smp_tag
  import daisy_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int IDX_W   = $clog2(NUM_DEV + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              live_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] sample_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NUM_DEV);

  logic [IDX_W-1:0] idx_q;

  assign valid_o  = done_i && live_i;
  assign sample_o = word_i;
  assign idx_o    = idx_q;

  // last node's sample comes first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= IDX_TOP;
    else if (valid_o) idx_q <= (idx_q == IDX_W'(1)) ? IDX_TOP : idx_q - 1'b1;
  end
endmodule

// File: rtl/daisy_cfg_seq.sv
module daisy_cfg_seq
  import daisy_cfg_pkg::*;
#(
  parameter int                        NUM_DEV    = 2,
  parameter int                        NUM_GROUPS = 3,
  parameter logic [NUM_GROUPS*WR_W-1:0] GROUP_LIST = {3'd3, 8'h50, 3'd2, 8'hE1, 3'd1, 8'h03},
  parameter logic [7:0]                MODE_DATA  = 8'h11,
  parameter int                        GAP_LIMIT  = 40,
  parameter int                        IDX_W      = $clog2(NUM_DEV + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_fs_i,
  input  logic              rx_sd_i,
  output logic              tx_fs_o,
  output logic              tx_sd_o,
  output logic [WORD_W-1:0] sample_o,
  output logic              sample_valid_o,
  output logic [IDX_W-1:0]  dev_idx_o,
  output logic              done_o,
  output logic              err_o
);
  logic [WORD_W-1:0] next_word, rx_word;
  logic              live, rx_done, rx_live_q;

  cfg_seq_ctrl #(
    .NUM_DEV(NUM_DEV), .NUM_GROUPS(NUM_GROUPS), .GROUP_LIST(GROUP_LIST),
    .MODE_DATA(MODE_DATA), .GAP_LIMIT(GAP_LIMIT)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_i(rx_fs_i),
    .word_o(next_word), .live_o(live), .err_o(err_o)
  );

  cfg_tx_shift u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rx_fs_i), .word_i(next_word),
    .fs_o(tx_fs_o), .sd_o(tx_sd_o)
  );

  cfg_rx_shift u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_i(rx_fs_i), .sd_i(rx_sd_i),
    .done_o(rx_done), .word_o(rx_word)
  );

  // frame validity is fixed by liveness at its own sync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_live_q <= 1'b0;
    else if (rx_fs_i) rx_live_q <= live;
  end

  cfg_smp_tag #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_tag (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(rx_done), .live_i(rx_live_q),
    .word_i(rx_word), .valid_o(sample_valid_o), .sample_o(sample_o),
    .idx_o(dev_idx_o)
  );

  assign done_o = live;
endmodule

// File: rtl/daisy_cfg_seq_chk.sv
module daisy_cfg_seq_chk #(
  parameter int NUM_DEV = 2,
  parameter int IDX_W   = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_fs_i,
  input logic             tx_fs_o,
  input logic             tx_sd_o,
  input logic             sample_valid_o,
  input logic [IDX_W-1:0] dev_idx_o,
  input logic             done_o,
  input logic             err_o
);
  // R3
  tx_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fs_o |-> $past(rx_fs_i));
  // R1
  ctl_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fs_o && !$past(done_o)) |-> tx_sd_o);
  // R6
  filler_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fs_o && $past(done_o)) |-> !tx_sd_o);
  // R5
  discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> done_o);
  // R7
  tag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |-> (dev_idx_o >= IDX_W'(1) && dev_idx_o <= IDX_W'(NUM_DEV)));
  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind daisy_cfg_seq daisy_cfg_seq_chk #(.NUM_DEV(NUM_DEV), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_fs_i(rx_fs_i), .tx_fs_o(tx_fs_o),
  .tx_sd_o(tx_sd_o), .sample_valid_o(sample_valid_o), .dev_idx_o(dev_idx_o),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_daisy_cfg_seq.sv
`timescale 1ns/1ps
module sim_daisy_cfg_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, sd = 1'b0;
  logic        tx_fs, tx_sd, s_vld, done, err;
  logic [15:0] smp;
  logic [1:0]  idx;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  daisy_cfg_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_fs_i(fs), .rx_sd_i(sd),
    .tx_fs_o(tx_fs), .tx_sd_o(tx_sd), .sample_o(smp),
    .sample_valid_o(s_vld), .dev_idx_o(idx), .done_o(done), .err_o(err)
  );

  // tx word and sample monitors, sampled mid-cycle
  logic [15:0] tx_acc, last_tx, last_smp;
  logic [1:0]  last_tag;
  int          tx_bits = 0, tx_seen = 0, smp_seen = 0;

  always @(negedge clk) begin
    if (tx_fs) begin
      tx_acc  = {15'd0, tx_sd};
      tx_bits = 1;
    end else if (tx_bits > 0 && tx_bits < 16) begin
      tx_acc  = {tx_acc[14:0], tx_sd};
      tx_bits = tx_bits + 1;
    end
    if (tx_bits == 16) begin
      last_tx = tx_acc;
      tx_seen = tx_seen + 1;
      tx_bits = 0;
    end
    if (s_vld) begin
      last_smp = smp;
      last_tag = idx;
      smp_seen = smp_seen + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] w);
    for (int b = 15; b >= 0; b--) begin
      @(negedge clk);
      fs = (b == 15);
      sd = w[b];
    end
    @(negedge clk);
    fs = 1'b0;
    sd = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  // rx word, expected tx word, expected sample valid, expected tag
  typedef struct packed {
    logic [15:0] rx;
    logic [15:0] tx;
    logic        vld;
    logic [1:0]  tag;
  } row_t;

  localparam row_t TAB [12] = '{
    '{16'h1111, 16'h8903, 1'b0, 2'd0},  // R1 R2 group 0
    '{16'h2222, 16'h8103, 1'b0, 2'd0},
    '{16'h3333, 16'h8AE1, 1'b0, 2'd0},  // R4 group 1
    '{16'h4444, 16'h82E1, 1'b0, 2'd0},
    '{16'h5555, 16'h8B50, 1'b0, 2'd0},
    '{16'h6666, 16'h8350, 1'b0, 2'd0},
    '{16'h7777, 16'h8811, 1'b0, 2'd0},  // R4 mode group
    '{16'h8888, 16'h8011, 1'b0, 2'd0},  // R5 discarded
    '{16'h035E, 16'h7FFF, 1'b1, 2'd2},  // R6 R7
    '{16'h3CFE, 16'h7FFF, 1'b1, 2'd1},
    '{16'hA5A5, 16'h7FFF, 1'b1, 2'd2},  // R7 wrap
    '{16'h0001, 16'h7FFF, 1'b1, 2'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int tx0, s0;
    repeat (3) @(negedge clk);
    chk("R10 tx_fs", tx_fs, 0);
    chk("R10 tx_sd", tx_sd, 0);
    chk("R10 valid", s_vld, 0);
    chk("R10 done", done, 0);
    chk("R10 err", err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      tx0 = tx_seen;
      s0  = smp_seen;
      frame(TAB[i].rx);
      chk("R3 one word per sync", tx_seen - tx0, 1);
      chk("R1 R2 R4 R6 tx word", last_tx, TAB[i].tx);
      chk("R5 R7 sample count", smp_seen - s0, {31'd0, TAB[i].vld});
      if (TAB[i].vld) begin
        chk("R7 sample word", last_smp, TAB[i].rx);
        chk("R7 tag", last_tag, TAB[i].tag);
      end
      if (i == 6) chk("R8 done before last word", done, 0);
      if (i == 7) chk("R8 done after last word", done, 1);
    end
    chk("R9 no err on gap-free run", err, 0);

    // R3 timing: tx_fs one cycle after sync
    @(negedge clk);
    fs = 1'b1;
    sd = 1'b0;
    @(negedge clk);
    fs = 1'b0;
    chk("R3 tx_fs next cycle", tx_fs, 1);
    chk("R6 filler msb", tx_sd, 0);
    repeat (20) @(negedge clk);

    // gap handling after a fresh reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 done after reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    frame(16'h0);
    chk("R2 first word", last_tx, 16'h8903);
    repeat (30) @(negedge clk);
    chk("R9 err on gap", err, 1);
    frame(16'h0);
    chk("R9 group restarts", last_tx, 16'h8903);
    frame(16'h0);
    chk("R2 nearer word", last_tx, 16'h8103);
    chk("R9 err sticky", err, 1);
    chk("R8 not done", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule